// File: doc/BRIEF.md
# I2S Transmit Clock Generator

This block derives every clock an I2S transmitter needs from a single peripheral clock. A fractional rate stage turns the peripheral clock into a pulse train at X/Y of its rate. Each pulse toggles a divide-by-two flip-flop, and that flip-flop is the transmit reference. The reference can drive the master clock pin. It also feeds an integer divider that produces the serial bit clock.

A source selector picks what the bit-clock divider counts. It can count the transmitter's own reference or the receiver's reference. A four-wire setting skips the divider and forwards the receiver's bit clock and word-select reference unchanged. A slave setting releases the bit-clock output enable and leaves the divider running. The whole block runs in the peripheral clock domain. When the divide ratios or the source change, the block clears itself so that no shortened pulse appears.

Top module: `i2s_txclk_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `mclk_o`, `bclk_o` and `ref_tick` are 0.
- R2: `rate` carries X in bits [15:8] and Y in bits [7:0]. With 0 < X <= Y, X is added to an accumulator every clock. Each time the sum reaches Y, Y is subtracted and the reference toggles. When X divides Y, the reference is high for Y/X cycles and low for Y/X cycles.
- R3: If X = 0 or X > Y, the reference never rises and `mclk_o` stays 0.
- R4: `ref_tick` is a one-cycle strobe. It is high exactly in the cycles where the transmit reference has just risen, one strobe per reference period.
- R5: `mclk_oe` equals `mclk_en`. `mclk_o` follows the reference when `mclk_en` is 1 and is 0 otherwise. The reference keeps running while `mclk_en` is 0.
- R6: `bit_div` value k gives N = k+1 (0 gives ÷1, 63 gives ÷64). For N > 1, `bclk_o` is high for ceil(N/2) periods of the selected reference and low for floor(N/2) periods.
- R7: With N = 1, `bclk_o` copies the selected reference one clock later, so the two have the same high and low widths.
- R8: `src_mode` = 2'd1 makes the divider count rising edges of `rx_ref` in place of the transmit reference. Values 2'd0 and 2'd3 select the transmit reference.
- R9: `src_mode` = 2'd2 (four-wire) connects `rx_bclk` to `bclk_o` and `rx_ws` to `ws_o` combinationally. In every other mode `ws_o` is 0.
- R10: `slave` = 1 drives `bclk_oe` to 0 and leaves the bit clock running. `slave` = 0 drives `bclk_oe` to 1.
- R11: A change of `rate`, `bit_div` or `src_mode` forces the reference and bit clock low on the next cycle. The first bit-clock pulse that follows has the full high width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate | input | 16 | X multiplier in [15:8], Y divider in [7:0] |
| bit_div | input | 6 | Bit-clock divide value minus one |
| src_mode | input | 2 | Bit-clock source: 0/3 own reference, 1 receiver reference, 2 four-wire |
| mclk_en | input | 1 | Enables the master clock output |
| slave | input | 1 | Bit clock is driven from outside; release its enable |
| rx_ref | input | 1 | Receiver reference level |
| rx_bclk | input | 1 | Receiver bit clock level |
| rx_ws | input | 1 | Receiver word-select reference |
| ref_tick | output | 1 | Strobe on each rise of the transmit reference |
| mclk_o | output | 1 | Master clock level |
| mclk_oe | output | 1 | Master clock output enable |
| bclk_o | output | 1 | Bit clock level |
| bclk_oe | output | 1 | Bit clock output enable |
| ws_o | output | 1 | Forwarded word-select reference in four-wire mode |

## Verification
The bench builds the block with its default widths: 8-bit X and Y fields and a 6-bit divide field. These widths make the ÷64 end of the bit divider reachable, as well as the ÷1 pass-through case and ratios where X exceeds Y. Period measurements cover even and odd N and fractional ratios with X greater than 1. They are also taken through the receiver-reference path. A reconfiguration made while the bit clock is high shows that the next pulse starts from low at full width.

// File: rtl/i2s_txclk_pkg.sv
// Shared types for the I2S transmit clock generator.
package i2s_txclk_pkg;
    typedef enum logic [1:0] {
        SRC_OWN    = 2'd0,
        SRC_RXREF  = 2'd1,
        SRC_RXBCLK = 2'd2,
        SRC_SPARE  = 2'd3
    } src_mode_e;
endpackage

// File: rtl/i2s_txclk_frac.sv
// Fractional X/Y rate stage followed by a divide-by-two toggle.
// Assumes X and Y are stable unless clr is pulsed in the same cycle they change.
module i2s_txclk_frac #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [FW-1:0] x,
    input  logic [FW-1:0] y,
    output logic          ref_lvl,
    output logic          ref_tick
);
    localparam int AW = FW + 1;

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic          valid;
    logic          pulse;

    // Accumulate and test against Y.
    always_comb begin
        valid = (x != '0) && (x <= y);
        sum   = acc + {1'b0, x};
        pulse = valid && (sum >= {1'b0, y});
    end

    // Advance the accumulator, toggle the reference, flag its rise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc      <= '0;
            ref_lvl  <= 1'b0;
            ref_tick <= 1'b0;
        end else begin
            ref_tick <= pulse && !ref_lvl;
            if (pulse) begin
                acc     <= sum - {1'b0, y};
                ref_lvl <= !ref_lvl;
            end else if (valid) begin
                acc <= sum;
            end
        end
    end

    // R4: the strobe marks exactly the rise of the reference
    a_r4_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |-> $rose(ref_lvl));
    a_r4_rise_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lvl) |-> ref_tick);
    // R3: an invalid ratio never lifts the reference
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !ref_lvl) |=> !ref_lvl);
    // R2: the accumulator stays below Y while the ratio is valid
    a_r2_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr && (acc < {1'b0, y})) |=> (clr || !valid || acc < {1'b0, y}));
endmodule

// File: rtl/i2s_txclk_bitdiv.sv
// Divides a reference level by N = n_m1 + 1 into a bit clock.
// For N > 1 it counts rising reference edges. High for ceil(N/2), low for floor(N/2).
// For N = 1 it copies the reference with one register of delay.
module i2s_txclk_bitdiv #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] n_m1,
    input  logic          src_lvl,
    output logic          bclk
);
    localparam int CW = DW + 1;

    logic [DW-1:0] cnt;
    logic [DW-1:0] cnt_nxt;
    logic [CW-1:0] half;
    logic          src_prev;
    logic          rise;

    // Edge detection, wrap of the counter, and the high-phase length.
    always_comb begin
        rise    = src_lvl && !src_prev;
        cnt_nxt = (cnt == n_m1) ? '0 : cnt + 1'b1;
        half    = ({1'b0, n_m1} + CW'(2)) >> 1;
    end

    // Count reference edges and shape the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            src_prev <= 1'b1;
            bclk     <= 1'b0;
        end else if (clr) begin
            cnt      <= n_m1;
            src_prev <= 1'b1;
            bclk     <= 1'b0;
        end else begin
            src_prev <= src_lvl;
            if (n_m1 == '0) begin
                bclk <= src_lvl;
            end else if (rise) begin
                cnt  <= cnt_nxt;
                bclk <= ({1'b0, cnt_nxt} < half);
            end
        end
    end

    // R6: the counter never passes the terminal value
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt <= n_m1) |=> (clr || cnt <= n_m1));
    // R6: the bit clock moves only on a reference edge when N > 1
    a_r6_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && n_m1 != '0 && !rise) |=> $stable(bclk));
endmodule

// File: rtl/i2s_txclk_gen.sv
// Top of the I2S transmit clock generator. Detects configuration changes,
// picks the bit-clock source, and drives the master clock, bit clock and
// word-select outputs. All logic is in the peripheral clock domain.
// The rx_* inputs are assumed to already be synchronous to clk.
module i2s_txclk_gen
    import i2s_txclk_pkg::*;
#(
    parameter int FW = 8,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2*FW-1:0] rate,
    input  logic [DW-1:0] bit_div,
    input  logic [1:0]    src_mode,
    input  logic          mclk_en,
    input  logic          slave,
    input  logic          rx_ref,
    input  logic          rx_bclk,
    input  logic          rx_ws,
    output logic          ref_tick,
    output logic          mclk_o,
    output logic          mclk_oe,
    output logic          bclk_o,
    output logic          bclk_oe,
    output logic          ws_o
);
    localparam int CFGW = 2 * FW + DW + 2;

    logic [CFGW-1:0] cfg;
    logic [CFGW-1:0] cfg_q;
    logic            clr;
    logic            ref_lvl;
    logic            src_lvl;
    logic            bclk_div;
    logic            four_wire;
    src_mode_e       mode;

    // Configuration snapshot and change detection.
    always_comb begin
        cfg  = {rate, bit_div, src_mode};
        clr  = (cfg != cfg_q);
        mode = src_mode_e'(src_mode);
    end

    // Hold the last configuration seen.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    i2s_txclk_frac #(.FW(FW)) u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .x        (rate[2*FW-1:FW]),
        .y        (rate[FW-1:0]),
        .ref_lvl  (ref_lvl),
        .ref_tick (ref_tick)
    );

    // Choose the reference that the bit divider counts.
    always_comb begin
        four_wire = (mode == SRC_RXBCLK);
        src_lvl   = (mode == SRC_RXREF) ? rx_ref : ref_lvl;
    end

    i2s_txclk_bitdiv #(.DW(DW)) u_bitdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .n_m1    (bit_div),
        .src_lvl (src_lvl),
        .bclk    (bclk_div)
    );

    // Output pins and their enables.
    always_comb begin
        mclk_o  = mclk_en && ref_lvl;
        mclk_oe = mclk_en;
        bclk_o  = four_wire ? rx_bclk : bclk_div;
        bclk_oe = !slave;
        ws_o    = four_wire && rx_ws;
    end

    // R11: a configuration change restarts both clocks from low
    a_r11_clean_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ref_lvl && !bclk_div && !ref_tick));
    // R1: nothing toggles on the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ref_lvl && !bclk_div));
endmodule

// File: tb/i2s_txclk_gen_test.sv
module i2s_txclk_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rate = 16'h0101;
    logic [5:0]  bit_div = 6'd0;
    logic [1:0]  src_mode = 2'd0;
    logic        mclk_en = 1'b1;
    logic        slave = 1'b0;
    logic        rx_ref = 1'b0;
    logic        rx_bclk = 1'b0;
    logic        rx_ws = 1'b0;
    logic        ref_tick, mclk_o, mclk_oe, bclk_o, bclk_oe, ws_o;

    int n_checks = 0;
    int n_fail = 0;
    bit rx_run = 1'b0;
    bit mon_done = 1'b0;

    typedef struct {
        int    sel;
        bit    skip;
        int    hi;
        int    lo;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_txclk_gen uut (
        .clk(clk), .rst_n(rst_n), .rate(rate), .bit_div(bit_div),
        .src_mode(src_mode), .mclk_en(mclk_en), .slave(slave),
        .rx_ref(rx_ref), .rx_bclk(rx_bclk), .rx_ws(rx_ws),
        .ref_tick(ref_tick), .mclk_o(mclk_o), .mclk_oe(mclk_oe),
        .bclk_o(bclk_o), .bclk_oe(bclk_oe), .ws_o(ws_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int sel);
        return (sel == 0) ? mclk_o : bclk_o;
    endfunction

    task automatic wait_lvl(input int sel, input logic lvl);
        for (int i = 0; i < 3000; i++) begin
            if (sig(sel) == lvl) return;
            @(negedge clk);
        end
    endtask

    task automatic count_lvl(input int sel, input logic lvl, output int n);
        n = 0;
        while (sig(sel) == lvl && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Receiver reference: high 5 cycles, low 5 cycles, while enabled.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (rx_run) begin
                c++;
                if (c == 5) begin
                    rx_ref = ~rx_ref;
                    c = 0;
                end
            end
        end
    end

    // Monitor: pop each expected waveform and measure it.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                int hi, lo;
                it = sb_q[0];
                wait_lvl(it.sel, 1'b0);
                wait_lvl(it.sel, 1'b1);
                if (it.skip) begin
                    wait_lvl(it.sel, 1'b0);
                    wait_lvl(it.sel, 1'b1);
                end
                count_lvl(it.sel, 1'b1, hi);
                count_lvl(it.sel, 1'b0, lo);
                chk(hi == it.hi, {it.req, " high width"}, hi, it.hi);
                chk(lo == it.lo, {it.req, " low width"}, lo, it.lo);
                void'(sb_q.pop_front());
                mon_done = 1'b1;
            end
        end
    end

    // Driver: queue one expected waveform and wait for the monitor.
    task automatic expect_wave(input int sel, input bit skip, input int hi, input int lo,
                               input string req);
        exp_t it;
        it.sel = sel; it.skip = skip; it.hi = hi; it.lo = lo; it.req = req;
        mon_done = 1'b0;
        sb_q.push_back(it);
        while (!mon_done) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] x, input logic [7:0] y, input logic [5:0] k,
                         input logic [1:0] m);
        @(negedge clk);
        rate = {x, y};
        bit_div = k;
        src_mode = m;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int ticks, bad;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!mclk_o && !bclk_o && !ref_tick, "R1 in reset", {mclk_o, bclk_o, ref_tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mclk_o && !bclk_o && !ref_tick, "R1 after reset", {mclk_o, bclk_o, ref_tick}, 0);

        // R2 / R7: X=1 Y=1, N=1
        setup(8'd1, 8'd1, 6'd0, 2'd0);
        expect_wave(0, 1, 1, 1, "R2 x1y1 ref");
        expect_wave(1, 1, 1, 1, "R7 n1 bclk");

        // R4: one strobe per reference period, always on a fresh rise
        ticks = 0; bad = 0;
        for (int i = 0; i < 40; i++) begin
            logic prev;
            prev = mclk_o;
            @(negedge clk);
            if (ref_tick) begin
                ticks++;
                if (!(mclk_o && !prev)) bad++;
            end
        end
        chk(ticks == 20, "R4 tick count", ticks, 20);
        chk(bad == 0, "R4 tick on rise", bad, 0);

        // R2 / R6: X=1 Y=2, N=4
        setup(8'd1, 8'd2, 6'd3, 2'd0);
        expect_wave(0, 1, 2, 2, "R2 x1y2 ref");
        expect_wave(1, 1, 8, 8, "R6 n4 bclk");

        // R2 / R6: X=2 Y=4, N=3 odd
        setup(8'd2, 8'd4, 6'd2, 2'd0);
        expect_wave(0, 1, 2, 2, "R2 x2y4 ref");
        expect_wave(1, 1, 8, 4, "R6 n3 odd bclk");

        // R6: N=64
        setup(8'd1, 8'd1, 6'd63, 2'd0);
        expect_wave(1, 1, 64, 64, "R6 n64 bclk");

        // R11: reconfigure while the bit clock is high
        wait_lvl(1, 1'b1);
        rate = {8'd1, 8'd3};
        bit_div = 6'd1;
        @(negedge clk);
        chk(!mclk_o && !bclk_o, "R11 cleared", {mclk_o, bclk_o}, 0);
        expect_wave(1, 0, 6, 6, "R11 first pulse");

        // R3: X=0 and X>Y keep the reference low
        setup(8'd0, 8'd5, 6'd0, 2'd0);
        ticks = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mclk_o || ref_tick) ticks++;
        end
        chk(ticks == 0, "R3 x zero", ticks, 0);
        setup(8'd6, 8'd5, 6'd0, 2'd0);
        ticks = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mclk_o || ref_tick) ticks++;
        end
        chk(ticks == 0, "R3 x above y", ticks, 0);

        // R5: master clock gating
        setup(8'd1, 8'd1, 6'd0, 2'd0);
        mclk_en = 1'b0;
        ticks = 0; bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mclk_o || mclk_oe) bad++;
            if (ref_tick) ticks++;
        end
        chk(bad == 0, "R5 gated low", bad, 0);
        chk(ticks == 10, "R5 ref keeps running", ticks, 10);
        mclk_en = 1'b1;
        @(negedge clk);
        chk(mclk_oe == 1'b1, "R5 oe", mclk_oe, 1);

        // R10: slave releases the enable, clock still runs
        slave = 1'b1;
        @(negedge clk);
        chk(bclk_oe == 1'b0, "R10 oe low", bclk_oe, 0);
        expect_wave(1, 1, 1, 1, "R10 bclk runs");
        slave = 1'b0;
        @(negedge clk);
        chk(bclk_oe == 1'b1, "R10 oe high", bclk_oe, 1);

        // R8: receiver reference source with own reference idle
        rx_run = 1'b1;
        setup(8'd0, 8'd1, 6'd1, 2'd1);
        expect_wave(1, 1, 10, 10, "R8 rx ref bclk");
        chk(mclk_o == 1'b0, "R8 own ref idle", mclk_o, 0);
        rx_run = 1'b0;

        // R9: four-wire pass-through, and ws_o quiet otherwise
        setup(8'd1, 8'd1, 6'd0, 2'd2);
        bad = 0;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            rx_bclk = p[0];
            rx_ws = p[1];
            #1;
            if (bclk_o != rx_bclk || ws_o != rx_ws) bad++;
        end
        chk(bad == 0, "R9 passthrough", bad, 0);
        setup(8'd1, 8'd1, 6'd0, 2'd0);
        rx_ws = 1'b1;
        #1;
        chk(ws_o == 1'b0, "R9 ws quiet", ws_o, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule